// File: doc/BRIEF.md
# Three-Address I2C Register Slave

This block is an I2C target that listens for three 7-bit addresses at once and gives each one its own view of a register space. The primary address reaches the general register bank. The master writes an index byte, then zero or more data bytes. A read on the primary address returns bytes starting at the stored index. Two secondary addresses, each of the form `1001xxx`, each reach one temperature sub-block. A secondary address is used through a 2-bit pointer. Pointers 0, 2 and 3 name 16-bit registers, which move as MSB then LSB. Pointer 1 names a 1-byte configuration register.

The block oversamples SCL and SDA with the system clock and pulls SDA low through `sda_oe` (open-drain drive). It talks to the surrounding register file through a one-cycle write strobe and a combinational read-data input. The register file supplies the primary address and the low bits of both secondary addresses, so software can move them. The block does not stretch the clock and does not answer the general-call address.

Top module: `i2c_multi_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper 7 bits equal `prim_addr`. A change of `prim_addr` takes effect at the next address byte.
- R2: An address byte that matches none of the three addresses gets no acknowledge. Every later byte up to the next start is ignored: nothing is written and SDA stays released.
- R3: On a primary write, the first byte after the address loads the index. Each further byte raises one `reg_wr` to space 0 at that index, with `reg_wdata = {8'h00, byte}`. The index then increments.
- R4: A primary read returns the byte at the current index, MSB-first on SDA. The index increments after each byte sent. It stays in place across transfers, so a later read with no new index continues from it. The master ends the read with a NACK.
- R5: Address `{4'b1001, sec_a_low}` selects space 1 and `{4'b1001, sec_b_low}` selects space 2. The write or read bit is bit 0 of the address byte.
- R6: On a secondary write, bits 1..0 of the first byte after the address set that address's own pointer. The pointer appears on `reg_addr[1:0]`. A read with no new pointer uses the stored pointer, and each secondary address keeps its own.
- R7: A read at pointer 0, 2 or 3 sends `reg_rdata[15:8]` and then `reg_rdata[7:0]`.
- R8: Pointer 1 is one byte wide. A single data byte writes `{8'h00, byte}`, and a read returns `reg_rdata[7:0]`.
- R9: A write at pointer 0, 2 or 3 takes an MSB byte and then an LSB byte. It raises exactly one `reg_wr` carrying `{msb, lsb}` after the LSB.
- R10: A start or stop condition anywhere ends the current transfer, and a byte cut short writes nothing. After reset the slave is idle: `sda_oe` is 0, `reg_wr` is 0 and `reg_space` is 3.
- R11: `reg_wr` lasts one clock for each byte, and `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| prim_addr | input | 7 | Primary 7-bit address |
| sec_a_low | input | 3 | Low 3 bits of the first secondary address |
| sec_b_low | input | 3 | Low 3 bits of the second secondary address |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_space | output | 2 | 0 primary bank, 1 first temperature block, 2 second, 3 none |
| reg_addr | output | 8 | Index (space 0) or pointer in bits 1..0 |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data for the current space and address |

## Verification
The hardest states to reach are mid-byte aborts and state that persists between transfers. The bench cuts a data byte off with a repeated start after four bits and then reads the target register back to show that it is unchanged. Index and pointer persistence are exercised by ending one transfer with a stop and starting a fresh read that sends no index or pointer. One secondary address is left parked on the configuration pointer while the other is moved, which shows that the two pointers are independent.

// File: rtl/i2c_ms_pkg.sv
package i2c_ms_pkg;

    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int PTR_W   = 2;
    localparam int BITS_W  = 4;
    localparam logic [3:0]        SEC_PREFIX = 4'b1001;
    localparam logic [PTR_W-1:0]  CFG_PTR    = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } eng_state_t;

    typedef enum logic [1:0] {
        SP_MAIN   = 2'd0,
        SP_TEMP_A = 2'd1,
        SP_TEMP_B = 2'd2,
        SP_NONE   = 2'd3
    } space_t;

    typedef enum logic [1:0] {
        RB_ADDR,
        RB_POINTER,
        RB_DATA
    } rx_role_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic is_wide_ptr(input logic [PTR_W-1:0] p);
        return p != CFG_PTR;
    endfunction

endpackage

// File: rtl/i2c_ms_line_sense.sv
module i2c_ms_line_sense
    import i2c_ms_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic scl_q;
    logic sda_q;
    logic scl_s;
    logic sda_s;

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/i2c_ms_addr_decode.sv
module i2c_ms_addr_decode
    import i2c_ms_pkg::*;
(
    input  logic [ADDR_W-1:0] addr7,
    input  logic [ADDR_W-1:0] prim_addr,
    input  logic [2:0]        sec_a_low,
    input  logic [2:0]        sec_b_low,
    output space_t            hit
);
    always_comb begin
        if (addr7 == prim_addr)
            hit = SP_MAIN;
        else if (addr7 == {SEC_PREFIX, sec_a_low})
            hit = SP_TEMP_A;
        else if (addr7 == {SEC_PREFIX, sec_b_low})
            hit = SP_TEMP_B;
        else
            hit = SP_NONE;
    end
endmodule

// File: rtl/i2c_ms_engine.sv
module i2c_ms_engine
    import i2c_ms_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  space_t            hit,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr7,
    output logic              sda_oe,
    output logic              reg_wr,
    output space_t            reg_space,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata
);
    eng_state_t        st;
    rx_role_t          role;
    space_t            space;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic [BYTE_W-1:0] index;
    logic [BYTE_W-1:0] msb_hold;
    logic [BITS_W-1:0] bitcnt;
    logic [PTR_W-1:0]  ptr_a;
    logic [PTR_W-1:0]  ptr_b;
    logic              rw;
    logic              wide_second;
    logic              tx_lo;
    logic              mack;
    logic              bump_idx;
    logic [PTR_W-1:0]  cur_ptr;
    logic [BYTE_W-1:0] tx_pick;
    logic              tx_wide;

    localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(BYTE_W);

    assign addr7     = shreg[BYTE_W-1:1];
    assign cur_ptr   = (space == SP_TEMP_B) ? ptr_b : ptr_a;
    assign reg_space = space;
    assign reg_addr  = (space == SP_MAIN) ? index : {{(BYTE_W-PTR_W){1'b0}}, cur_ptr};
    assign tx_wide   = (space != SP_MAIN) && is_wide_ptr(cur_ptr);

    always_comb begin
        if (tx_wide && !tx_lo)
            tx_pick = rd_data[WORD_W-1:BYTE_W];
        else
            tx_pick = rd_data[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            role        <= RB_ADDR;
            space       <= SP_NONE;
            shreg       <= '0;
            txsh        <= '0;
            index       <= '0;
            msb_hold    <= '0;
            bitcnt      <= '0;
            ptr_a       <= '0;
            ptr_b       <= '0;
            rw          <= 1'b0;
            wide_second <= 1'b0;
            tx_lo       <= 1'b0;
            mack        <= 1'b0;
            bump_idx    <= 1'b0;
            sda_oe      <= 1'b0;
            reg_wr      <= 1'b0;
            reg_wdata   <= '0;
        end else begin
            reg_wr <= 1'b0;
            if (evt.start) begin
                st          <= ST_RX;
                role        <= RB_ADDR;
                space       <= SP_NONE;
                bitcnt      <= '0;
                sda_oe      <= 1'b0;
                wide_second <= 1'b0;
                tx_lo       <= 1'b0;
                bump_idx    <= 1'b0;
            end else if (evt.stop) begin
                st     <= ST_IDLE;
                space  <= SP_NONE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (evt.scl_rise && bitcnt != LAST_BIT) begin
                            shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (evt.scl_fall && bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            case (role)
                                RB_ADDR: begin
                                    if (hit != SP_NONE) begin
                                        space  <= hit;
                                        rw     <= shreg[0];
                                        sda_oe <= 1'b1;
                                        st     <= ST_RX_ACK;
                                        role   <= RB_POINTER;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                RB_POINTER: begin
                                    sda_oe      <= 1'b1;
                                    st          <= ST_RX_ACK;
                                    role        <= RB_DATA;
                                    wide_second <= 1'b0;
                                    if (space == SP_MAIN)
                                        index <= shreg;
                                    else if (space == SP_TEMP_A)
                                        ptr_a <= shreg[PTR_W-1:0];
                                    else
                                        ptr_b <= shreg[PTR_W-1:0];
                                end
                                default: begin
                                    sda_oe <= 1'b1;
                                    st     <= ST_RX_ACK;
                                    if (space == SP_MAIN) begin
                                        reg_wr    <= 1'b1;
                                        reg_wdata <= {{(WORD_W-BYTE_W){1'b0}}, shreg};
                                        bump_idx  <= 1'b1;
                                    end else if (!is_wide_ptr(cur_ptr)) begin
                                        reg_wr    <= 1'b1;
                                        reg_wdata <= {{(WORD_W-BYTE_W){1'b0}}, shreg};
                                    end else if (!wide_second) begin
                                        msb_hold    <= shreg;
                                        wide_second <= 1'b1;
                                    end else begin
                                        reg_wr      <= 1'b1;
                                        reg_wdata   <= {msb_hold, shreg};
                                        wide_second <= 1'b0;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (evt.scl_fall) begin
                            if (bump_idx) begin
                                index    <= index + 1'b1;
                                bump_idx <= 1'b0;
                            end
                            if (rw) begin
                                txsh   <= tx_pick;
                                sda_oe <= ~tx_pick[BYTE_W-1];
                                if (tx_wide) tx_lo <= ~tx_lo;
                                st     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise)
                            bitcnt <= bitcnt + 1'b1;
                        if (evt.scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                st     <= ST_TX_ACK;
                                if (space == SP_MAIN) index <= index + 1'b1;
                            end else begin
                                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txsh[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt.scl_rise)
                            mack <= ~evt.sda;
                        if (evt.scl_fall) begin
                            if (mack) begin
                                txsh   <= tx_pick;
                                sda_oe <= ~tx_pick[BYTE_W-1];
                                if (tx_wide) tx_lo <= ~tx_lo;
                                st     <= ST_TX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_multi_slave.sv
module i2c_multi_slave
    import i2c_ms_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] prim_addr,
    input  logic [2:0]        sec_a_low,
    input  logic [2:0]        sec_b_low,
    output logic              reg_wr,
    output logic [1:0]        reg_space,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata
);
    bus_evt_t          bus_evt;
    space_t            hit;
    space_t            space_o;
    logic [ADDR_W-1:0] addr7;

    i2c_ms_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (bus_evt)
    );

    i2c_ms_addr_decode u_dec (
        .addr7     (addr7),
        .prim_addr (prim_addr),
        .sec_a_low (sec_a_low),
        .sec_b_low (sec_b_low),
        .hit       (hit)
    );

    i2c_ms_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .evt       (bus_evt),
        .hit       (hit),
        .rd_data   (reg_rdata),
        .addr7     (addr7),
        .sda_oe    (sda_oe),
        .reg_wr    (reg_wr),
        .reg_space (space_o),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

    assign reg_space = space_o;
endmodule

// File: rtl/i2c_ms_checker.sv
module i2c_ms_checker (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_oe,
    input logic reg_wr,
    input logic start_evt,
    input logic stop_evt
);
    assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_in);

    assert_wr_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> !scl_in);

    assert_start_release_R10: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !sda_oe);

    assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (!sda_oe && !reg_wr));
endmodule

bind i2c_multi_slave i2c_ms_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .reg_wr    (reg_wr),
    .start_evt (bus_evt.start),
    .stop_evt  (bus_evt.stop)
);

// File: tb/i2c_multi_slave_test.sv
module i2c_multi_slave_test;
    localparam int Q = 10;
    localparam logic [15:0] VEC [4] = '{16'h103C, 16'h7FC3, 16'hFF01, 16'h22AA};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [6:0]  prim_addr = 7'h2D;
    logic [2:0]  sec_a = 3'b010;
    logic [2:0]  sec_b = 3'b101;
    logic        sda_oe;
    logic        sda_line;
    logic        reg_wr;
    logic [1:0]  reg_space;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;

    logic [7:0]  main_mem [256];
    logic [15:0] ta [4];
    logic [15:0] tb [4];
    int          wr_count = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    i2c_multi_slave uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .prim_addr(prim_addr), .sec_a_low(sec_a), .sec_b_low(sec_b),
        .reg_wr(reg_wr), .reg_space(reg_space), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_main(input int i);
        return 8'((i * 3) + 7);
    endfunction
    function automatic logic [15:0] init_ta(input int i);
        return 16'hA000 + 16'(i) * 16'h0111;
    endfunction
    function automatic logic [15:0] init_tb(input int i);
        return 16'hB000 + 16'(i) * 16'h0101;
    endfunction

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_count <= wr_count + 1;
            case (reg_space)
                2'd0: main_mem[reg_addr] <= reg_wdata[7:0];
                2'd1: ta[reg_addr[1:0]] <= reg_wdata;
                2'd2: tb[reg_addr[1:0]] <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_space)
            2'd0:    reg_rdata = {8'h00, main_mem[reg_addr]};
            2'd1:    reg_rdata = ta[reg_addr[1:0]];
            2'd2:    reg_rdata = tb[reg_addr[1:0]];
            default: reg_rdata = 16'h0000;
        endcase
    end

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic qwait;
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        m_sda = 1'b1; qwait;
        scl = 1'b1;   qwait;
        m_sda = 1'b0; qwait;
        scl = 1'b0;   qwait;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; qwait;
        scl = 1'b1;   qwait;
        m_sda = 1'b1; qwait;
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qwait;
        scl = 1'b1; qwait; qwait;
        scl = 1'b0; qwait;
    endtask

    task automatic recv_bit(output logic v);
        m_sda = 1'b1; qwait;
        scl = 1'b1; qwait;
        v = sda_line; qwait;
        scl = 1'b0; qwait;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(r);
        ack = ~r;
    endtask

    task automatic rd_byte(output logic [7:0] b, input logic give_ack);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(v);
            b[i] = v;
        end
        send_bit(~give_ack);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] pw, pr, aw, ar, bw, br;
        int         wc;

        for (int i = 0; i < 256; i++) main_mem[i] = init_main(i);
        for (int i = 0; i < 4; i++) begin
            ta[i] = init_ta(i);
            tb[i] = init_tb(i);
        end
        pw = {7'h2D, 1'b0}; pr = {7'h2D, 1'b1};
        aw = {4'b1001, 3'b010, 1'b0}; ar = {4'b1001, 3'b010, 1'b1};
        bw = {4'b1001, 3'b101, 1'b0}; br = {4'b1001, 3'b101, 1'b1};

        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R10 reset state
        check(sda_oe == 1'b0 && reg_wr == 1'b0, "R10 reset outputs", {14'd0, sda_oe, reg_wr}, 16'h0000);
        check(reg_space == 2'd3, "R10 reset space", {14'd0, reg_space}, 16'h0003);

        // Vector table: primary write then pointer-set + repeated-start read (R1, R3, R4)
        foreach (VEC[k]) begin
            bus_start; wr_byte(pw, ack);
            check(ack, "R1 primary address ack", {15'd0, ack}, 16'h0001);
            wr_byte(VEC[k][15:8], ack); wr_byte(VEC[k][7:0], ack); bus_stop;
            bus_start; wr_byte(pw, ack); wr_byte(VEC[k][15:8], ack);
            bus_start; wr_byte(pr, ack); rd_byte(b0, 1'b0); bus_stop;
            check(b0 == VEC[k][7:0], "R3 R4 write then read back", {8'd0, b0}, {8'd0, VEC[k][7:0]});
        end

        // R2 non-matching address: no ack, later bytes ignored
        wc = wr_count;
        bus_start; wr_byte(8'h58, ack);
        check(!ack, "R2 no ack on foreign address", {15'd0, ack}, 16'h0000);
        wr_byte(8'h05, ack);
        check(!ack, "R2 later byte not acked", {15'd0, ack}, 16'h0000);
        wr_byte(8'h77, ack); bus_stop;
        check(wr_count == wc, "R2 no write after foreign address", 16'(wr_count), 16'(wc));

        // R4 multi-byte read with auto increment and index persistence
        bus_start; wr_byte(pw, ack); wr_byte(8'h40, ack); bus_stop;
        bus_start; wr_byte(pr, ack); rd_byte(b0, 1'b1); rd_byte(b1, 1'b1); rd_byte(b2, 1'b0); bus_stop;
        check(b0 == init_main(8'h40), "R4 read byte 0", {8'd0, b0}, {8'd0, init_main(8'h40)});
        check(b1 == init_main(8'h41), "R4 read byte 1", {8'd0, b1}, {8'd0, init_main(8'h41)});
        check(b2 == init_main(8'h42), "R4 read byte 2", {8'd0, b2}, {8'd0, init_main(8'h42)});
        bus_start; wr_byte(pr, ack); rd_byte(b0, 1'b0); bus_stop;
        check(b0 == init_main(8'h43), "R4 index kept across transfers", {8'd0, b0}, {8'd0, init_main(8'h43)});

        // R3 multi-byte write, R11 one strobe per byte
        wc = wr_count;
        bus_start; wr_byte(pw, ack); wr_byte(8'h80, ack); wr_byte(8'h11, ack); wr_byte(8'h22, ack); bus_stop;
        check(wr_count == wc + 2, "R11 one write strobe per byte", 16'(wr_count - wc), 16'd2);
        bus_start; wr_byte(pw, ack); wr_byte(8'h80, ack);
        bus_start; wr_byte(pr, ack); rd_byte(b0, 1'b1); rd_byte(b1, 1'b0); bus_stop;
        check({b0, b1} == 16'h1122, "R3 consecutive writes", {b0, b1}, 16'h1122);

        // R5 R7 secondary A pointer 0, repeated start, MSB then LSB
        bus_start; wr_byte(aw, ack);
        check(ack, "R5 first secondary address ack", {15'd0, ack}, 16'h0001);
        wr_byte(8'h00, ack);
        bus_start; wr_byte(ar, ack); rd_byte(b0, 1'b1); rd_byte(b1, 1'b0); bus_stop;
        check({b0, b1} == init_ta(0), "R7 two-byte read order", {b0, b1}, init_ta(0));

        // R6 preset pointer read
        bus_start; wr_byte(aw, ack); wr_byte(8'h03, ack); bus_stop;
        bus_start; wr_byte(ar, ack); rd_byte(b0, 1'b1); rd_byte(b1, 1'b0); bus_stop;
        check({b0, b1} == init_ta(3), "R6 read at preset pointer", {b0, b1}, init_ta(3));

        // R8 config write and one-byte read on secondary B
        bus_start; wr_byte(bw, ack);
        check(ack, "R5 second secondary address ack", {15'd0, ack}, 16'h0001);
        wr_byte(8'h01, ack); wr_byte(8'h5A, ack); bus_stop;
        bus_start; wr_byte(br, ack); rd_byte(b0, 1'b0); bus_stop;
        check(b0 == 8'h5A, "R8 config byte", {8'd0, b0}, 16'h005A);

        // R9 two-byte write on secondary A
        wc = wr_count;
        bus_start; wr_byte(aw, ack); wr_byte(8'h02, ack); wr_byte(8'h12, ack); wr_byte(8'h34, ack); bus_stop;
        check(wr_count == wc + 1, "R9 single strobe for word", 16'(wr_count - wc), 16'd1);
        bus_start; wr_byte(ar, ack); rd_byte(b0, 1'b1); rd_byte(b1, 1'b0); bus_stop;
        check({b0, b1} == 16'h1234, "R9 word written", {b0, b1}, 16'h1234);

        // R6 pointer of B untouched by A traffic
        bus_start; wr_byte(br, ack); rd_byte(b0, 1'b0); bus_stop;
        check(b0 == 8'h5A, "R6 separate pointers", {8'd0, b0}, 16'h005A);

        // R10 byte cut short by repeated start writes nothing
        wc = wr_count;
        bus_start; wr_byte(pw, ack); wr_byte(8'h90, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_start; bus_stop;
        check(wr_count == wc, "R10 aborted byte not written", 16'(wr_count - wc), 16'd0);
        bus_start; wr_byte(pw, ack); wr_byte(8'h90, ack);
        bus_start; wr_byte(pr, ack); rd_byte(b0, 1'b0); bus_stop;
        check(b0 == init_main(8'h90), "R10 register unchanged", {8'd0, b0}, {8'd0, init_main(8'h90)});

        // R1 reprogrammed primary address
        prim_addr = 7'h33;
        bus_start; wr_byte(pw, ack); bus_stop;
        check(!ack, "R1 old primary address ignored", {15'd0, ack}, 16'h0000);
        bus_start; wr_byte({7'h33, 1'b0}, ack); bus_stop;
        check(ack, "R1 new primary address acked", {15'd0, ack}, 16'h0001);
        check(sda_oe == 1'b0, "R11 SDA released when idle", {15'd0, sda_oe}, 16'h0000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule